// File: doc/BRIEF.md
# Semi-logarithmic histogram bin mapper

This block turns an unsigned sample into the index of a histogram bin whose width grows with the sample's magnitude. Each power-of-two range [2^e, 2^(e+1)) is one group of bins, and a run-time granularity `g` splits every group into 2^g bins of equal width. Small samples, below 2^g, form a linear region in which every value gets its own bin. The index is built like a floating-point code: the position of the leading one acts as the exponent, and the g bits below it act as a truncated significand.

A sample and its granularity are presented together with a valid strobe. One clock later the bin index, a zero-sample flag and the delayed strobe come out of registers. The block accepts a new sample on every cycle and cannot be stalled. A granularity above the configured maximum is clamped to that maximum.

Top module: `slm_bin_mapper`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_bin` and `out_zero` are all 0.
- R2: With the effective granularity g, a sample s with s < 2^g gives `out_bin` = s.
- R3: With s >= 2^g and e = floor(log2 s), `out_bin` = ((e - g + 1) << g) + (the g bits of s directly below its leading one), taken by truncation. For example, with g = 2, samples 16..19 give 12, 20..23 give 13, 24..27 give 14 and 28..31 give 15.
- R4: With g = 0, a nonzero sample gives floor(log2 s) + 1. For example, 1 gives 1, 3 gives 2, 7 gives 3, 8 gives 4 and 63 gives 6.
- R5: A zero sample gives `out_bin` = 0 and `out_zero` = 1. Any nonzero sample gives `out_zero` = 0.
- R6: `out_valid` equals the value `in_valid` had at the previous rising clock edge, and `out_bin` and `out_zero` belong to that sample.
- R7: When `in_gran` is greater than JMAX, the block maps the sample as if `in_gran` were JMAX.
- R8: In a cycle with `in_valid` low, `out_bin` and `out_zero` keep their values at the next edge.
- R9: For a fixed granularity, `out_bin` never decreases as the sample increases. This includes the step from 2^g - 1 to 2^g: with g = 2, 7 gives 7 and 8 gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | W | Unsigned sample |
| in_gran | input | JW = $clog2(JMAX+1) | Sub-bin granularity g (2^g bins per octave) |
| out_valid | output | 1 | Registered strobe, one cycle after `in_valid` |
| out_bin | output | OW | Bin index |
| out_zero | output | 1 | Set when the sample was zero |

## Verification
The assertions check five things on every cycle: the one-cycle strobe delay, the value held while no sample arrives, the zero-sample result and flag, and the pass-through value in the linear region. The logarithmic formula, the clamping of large granularities and monotonicity hold only across many samples. The bench shows them with a reference model written as a log2 loop, compared on every cycle over all samples 0..4095 for each granularity, plus wide samples near the top of the range and hand-picked table values.

// File: rtl/slm_pkg.sv
package slm_pkg;

  // Width of the bin index: the largest index for granularity jmax is
  // below (w - jmax + 1) << jmax; never narrower than jmax + 1 bits.
  function automatic int slm_out_width(input int w, input int jmax);
    int top;
    int wd;
    top = (w - jmax + 1) << jmax;
    wd  = $clog2(top);
    if (wd < jmax + 1) wd = jmax + 1;
    return wd;
  endfunction

endpackage

// File: rtl/slm_lod.sv
// Leading-one detector: position of the most significant set bit.
module slm_lod #(
  parameter int W  = 32,
  parameter int EW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [EW-1:0] pos,
  output logic          found
);

  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (vec[k]) begin
        pos   = EW'(k);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/slm_frac.sv
// Window extraction: returns sample >> (lead - gran), limited to JMAX+1 bits.
// In the logarithmic region this is the leading one followed by gran bits.
module slm_frac #(
  parameter int W    = 32,
  parameter int JMAX = 8,
  parameter int EW   = $clog2(W),
  parameter int JW   = $clog2(JMAX + 1)
) (
  input  logic [W-1:0]  sample,
  input  logic [EW-1:0] lead,
  input  logic [JW-1:0] gran,
  output logic [JMAX:0] window
);

  int shamt;

  always_comb begin
    shamt = int'(lead) - int'(gran);
    if (shamt < 0) shamt = 0;
  end

  generate
    for (genvar k = 0; k <= JMAX; k++) begin : g_win
      always_comb begin
        if (shamt + k < W) window[k] = sample[shamt + k];
        else               window[k] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/slm_compose.sv
// Assembles the bin index from exponent, window and linear-region bypass.
module slm_compose #(
  parameter int W    = 32,
  parameter int JMAX = 8,
  parameter int OW   = 13,
  parameter int EW   = $clog2(W),
  parameter int JW   = $clog2(JMAX + 1)
) (
  input  logic [JMAX-1:0] low_bits,
  input  logic [EW-1:0]   lead,
  input  logic            found,
  input  logic [JW-1:0]   gran,
  input  logic [JMAX:0]   window,
  output logic [OW-1:0]   bin,
  output logic            zero
);

  logic          linear;
  logic [OW-1:0] octave;
  logic [OW-1:0] log_bin;

  always_comb begin
    linear  = !found || (int'(lead) < int'(gran));
    // window = 2^g + sub, so (e-g)<<g + window = (e-g+1)<<g + sub
    octave  = (OW'(lead) - OW'(gran)) << gran;
    log_bin = octave + OW'(window);
    zero    = !found;
    if (linear) bin = OW'(low_bits);
    else        bin = log_bin;
  end

endmodule

// File: rtl/slm_bin_mapper.sv
module slm_bin_mapper
  import slm_pkg::*;
#(
  parameter int W    = 32,
  parameter int JMAX = 8,
  parameter int JW   = $clog2(JMAX + 1),
  parameter int OW   = slm_out_width(W, JMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_sample,
  input  logic [JW-1:0] in_gran,
  output logic          out_valid,
  output logic [OW-1:0] out_bin,
  output logic          out_zero
);

  localparam int EW = $clog2(W);

  logic [JW-1:0] gran_eff;
  logic [EW-1:0] lead;
  logic          found;
  logic [JMAX:0] window;
  logic [OW-1:0] bin_d;
  logic          zero_d;

  logic          valid_q;
  logic [OW-1:0] bin_q;
  logic          zero_q;
  logic [OW-1:0] bin_nx;
  logic          zero_nx;

  always_comb begin
    if (in_gran > JW'(JMAX)) gran_eff = JW'(JMAX);
    else                     gran_eff = in_gran;
  end

  slm_lod #(.W(W), .EW(EW)) lod_i (
    .vec   (in_sample),
    .pos   (lead),
    .found (found)
  );

  slm_frac #(.W(W), .JMAX(JMAX), .EW(EW), .JW(JW)) frac_i (
    .sample (in_sample),
    .lead   (lead),
    .gran   (gran_eff),
    .window (window)
  );

  slm_compose #(.W(W), .JMAX(JMAX), .OW(OW), .EW(EW), .JW(JW)) comp_i (
    .low_bits (in_sample[JMAX-1:0]),
    .lead     (lead),
    .found    (found),
    .gran     (gran_eff),
    .window   (window),
    .bin      (bin_d),
    .zero     (zero_d)
  );

  // next state: data registers load only when a sample arrives
  always_comb begin
    bin_nx  = bin_q;
    zero_nx = zero_q;
    if (in_valid) begin
      bin_nx  = bin_d;
      zero_nx = zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bin_q   <= '0;
      zero_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      bin_q   <= bin_nx;
      zero_q  <= zero_nx;
    end
  end

  assign out_valid = valid_q;
  assign out_bin   = bin_q;
  assign out_zero  = zero_q;

endmodule

// File: rtl/slm_bin_mapper_chk.sv
module slm_bin_mapper_chk #(
  parameter int W    = 32,
  parameter int JMAX = 8,
  parameter int JW   = 4,
  parameter int OW   = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_sample,
  input logic [JW-1:0] in_gran,
  input logic          out_valid,
  input logic [OW-1:0] out_bin,
  input logic          out_zero
);

  int  g_eff;
  logic small_in;

  always_comb begin
    g_eff    = (int'(in_gran) > JMAX) ? JMAX : int'(in_gran);
    small_in = 64'(in_sample) < (64'd1 << g_eff);
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_bin) && $stable(out_zero))); // R8
  AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == '0) |=> (out_zero && out_bin == '0)); // R5
  AST_NONZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample != '0) |=> !out_zero); // R5
  AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && small_in) |=> (64'(out_bin) == 64'($past(in_sample)))); // R2

endmodule

bind slm_bin_mapper slm_bin_mapper_chk #(.W(W), .JMAX(JMAX), .JW(JW), .OW(OW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .in_gran   (in_gran),
  .out_valid (out_valid),
  .out_bin   (out_bin),
  .out_zero  (out_zero)
);

// File: tb/slm_bin_mapper_tb_top.sv
module slm_bin_mapper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 32;
  localparam int JMAX = 8;
  localparam int JW   = $clog2(JMAX + 1);
  localparam int OW   = slm_pkg::slm_out_width(W, JMAX);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_sample;
  logic [JW-1:0] in_gran;
  logic          out_valid;
  logic [OW-1:0] out_bin;
  logic          out_zero;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic          exp_valid = 0;
  longint        exp_bin   = 0;
  logic          exp_zero  = 0;
  string         exp_tag   = "R1";
  bit            mono_on   = 0;
  longint        mono_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slm_bin_mapper #(.W(W), .JMAX(JMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_gran(in_gran), .out_valid(out_valid), .out_bin(out_bin), .out_zero(out_zero)
  );

  function automatic longint ref_map(input longint unsigned s, input int g);
    int e;
    longint unsigned t;
    longint unsigned sub;
    if (g > JMAX) g = JMAX;
    if (s < (64'd1 << g)) return longint'(s);
    e = 0;
    t = s;
    while (t > 1) begin
      t = t >> 1;
      e++;
    end
    sub = (s >> (e - g)) & ((64'd1 << g) - 1);
    return longint'((longint'(e - g + 1) << g) + sub);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // compare outputs produced by the previous drive, then drive the next one
  task automatic step(input logic v, input longint unsigned s, input int g);
    @(negedge clk);
    checks++;
    if (out_valid !== exp_valid || longint'(out_bin) != exp_bin || out_zero !== exp_zero) begin
      errors++;
      $display("FAIL %s: got valid=%0b bin=%0d zero=%0b expected valid=%0b bin=%0d zero=%0b",
               exp_tag, out_valid, out_bin, out_zero, exp_valid, exp_bin, exp_zero);
    end
    if (mono_on && exp_valid) begin
      checks++;
      if (longint'(out_bin) < mono_prev) begin
        errors++;
        $display("FAIL R9: got bin=%0d expected at least %0d", out_bin, mono_prev);
      end
      mono_prev = longint'(out_bin);
    end
    in_valid  = v;
    in_sample = W'(s);
    in_gran   = JW'(g);
    exp_valid = v;
    if (v) begin
      exp_bin  = ref_map(s, g);
      exp_zero = (s == 0);
      if (g > JMAX)                      exp_tag = "R7";
      else if (s == 0)                   exp_tag = "R5";
      else if (s < (64'd1 << g))         exp_tag = "R2";
      else if (g == 0)                   exp_tag = "R4";
      else                               exp_tag = "R3";
    end else begin
      exp_tag = "R8 R6";
    end
  endtask

  task automatic spot(input longint unsigned s, input int g, input longint want, input string tag);
    step(1'b1, s, g);
    step(1'b0, 0, 0);
    checks++;
    if (longint'(out_bin) != want) begin
      errors++;
      $display("FAIL %s: sample %0d gran %0d got bin=%0d expected %0d", tag, s, g, out_bin, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end of run expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sample = '0;
    in_gran = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_bin !== '0 || out_zero !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%0b bin=%0d zero=%0b expected 0 0 0", out_valid, out_bin, out_zero);
    end
    rst_n = 1'b1;

    // table values: R4 for g = 0, R3 / R2 / R9 elsewhere
    spot(1, 0, 1, "R4");  spot(3, 0, 2, "R4");  spot(7, 0, 3, "R4");
    spot(8, 0, 4, "R4");  spot(63, 0, 6, "R4");
    spot(8, 1, 6, "R3");  spot(11, 1, 6, "R3"); spot(12, 1, 7, "R3");
    spot(15, 1, 7, "R3"); spot(63, 1, 11, "R3");
    spot(16, 2, 12, "R3"); spot(23, 2, 13, "R3"); spot(27, 2, 14, "R3");
    spot(31, 2, 15, "R3"); spot(7, 2, 7, "R9");   spot(8, 2, 8, "R9");
    spot(17, 3, 16, "R3"); spot(36, 3, 25, "R3"); spot(33, 4, 32, "R3");
    spot(63, 4, 47, "R3"); spot(63, 5, 63, "R3"); spot(63, 6, 63, "R2");
    spot(0, 3, 0, "R5");

    // hold: idle cycles with changing inputs must not move the outputs (R8)
    step(1'b1, 1000, 3);
    step(1'b0, 5, 0);
    step(1'b0, 0, 7);
    step(1'b0, 123456, 2);

    // clamp above JMAX (R7)
    for (int g = JMAX + 1; g < (1 << JW); g++) begin
      step(1'b1, 4095, g);
      step(1'b1, 70000, g);
      step(1'b1, 200, g);
    end

    // wide samples near the top of the range
    for (int g = 0; g <= JMAX; g++) begin
      step(1'b1, 64'hFFFF_FFFF, g);
      step(1'b1, 64'h8000_0000, g);
      step(1'b1, 64'h0001_2345, g);
    end

    // exhaustive sweep per granularity with monotonic tracking (R9)
    for (int g = 0; g <= JMAX; g++) begin
      step(1'b0, 0, g);
      mono_on = 1;
      mono_prev = 0;
      for (int s = 0; s < 4096; s++) step(1'b1, s, g);
      step(1'b0, 0, g);
      mono_on = 0;
    end
    step(1'b0, 0, 0);
    summary();
  end

endmodule